// File: doc/BRIEF.md
# Transmit Status Writeback Engine

This block handles the status side of a transmit descriptor ring in an Ethernet MAC DMA. The data mover hands it one event per fragment, carrying the byte count, the error flag, the last-fragment flag and the interrupt-request flag for that fragment. The block turns each event into one 32-bit status word. It then writes that word to memory at the status base address plus four times the running status index.

A status for a fragment that is not the last one is written as soon as the fragment is accepted. A status for the last fragment of a packet is held back until the line side reports that the packet has finished transmitting. Every status that has been written waits in a small queue of outstanding statuses until the memory system acknowledges that it is committed. One acknowledgement may cover up to three statuses at once. Only on that acknowledgement does the consume index advance, and only then are the done and error interrupt flags pulsed towards the interrupt status register.

Software reads a ring-full indication that compares its produce index, advanced by one, with the consume index. Because of this rule one descriptor slot always stays unused.

Top module: `txstat_wb`

## Requirements
- R1: After reset `consume_idx` is 0, `wr_valid`, `int_done_set` and `int_err_set` are 0, and `frag_ready` is 1.
- R2: The status word `wr_data` holds the error flag in bit 31, the last-fragment flag in bit 30 and the 11-bit byte count in bits 10:0; all other bits are 0.
- R3: `wr_addr` equals `cfg_status_base + 4 * s`, where the status index `s` starts at 0, increments once per accepted write and wraps to 0 after reaching `cfg_desc_last`.
- R4: For a non-last fragment, `wr_valid` rises in the cycle after the fragment is accepted, without waiting for `tx_done`.
- R5: For a last fragment, no write is presented until a `tx_done` pulse arrives; the write appears in the cycle after that pulse, and its error flag is the fragment error ORed with `tx_done_err`. A `tx_done` pulse that arrives while no last fragment is waiting is ignored and is not remembered.
- R6: `frag_ready` is 0 while a status is staged and not yet written, so only one fragment is held at a time.
- R7: `consume_idx` changes only in the cycle after a commit acknowledgement. It advances by min(`cm_count`, outstanding statuses) and wraps to 0 after `cfg_desc_last`. A count of 0 has no effect.
- R8: `int_done_set` pulses for one cycle after a commit that covers a status whose interrupt flag was set, and `int_err_set` does the same for a status whose error flag was set. Neither pulses without a commit.
- R9: At most `PEND_DEPTH` (default 4) statuses can be written but not yet committed; while that many are outstanding, `wr_valid` stays 0.
- R10: `ring_full` is 1 exactly when `sw_produce_idx` advanced by one (wrapping after `cfg_desc_last`) equals `consume_idx`.
- R11: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_status_base | input | 32 | Byte address of status entry 0 |
| cfg_desc_last | input | 8 | Descriptor count minus one (wrap point) |
| sw_produce_idx | input | 8 | Produce index written by software |
| frag_valid | input | 1 | Fragment accepted event offered |
| frag_ready | output | 1 | Engine can take a fragment event |
| frag_last | input | 1 | Fragment is the last of its packet |
| frag_irq | input | 1 | Descriptor interrupt flag |
| frag_err | input | 1 | Error seen while fetching the fragment |
| frag_bytes | input | 11 | Bytes carried by the fragment |
| tx_done | input | 1 | Line transmission of the packet finished (pulse) |
| tx_done_err | input | 1 | Line transmission error, valid with tx_done |
| wr_valid | output | 1 | Status write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Status write byte address |
| wr_data | output | 32 | Status word |
| cm_valid | input | 1 | Commit acknowledgement |
| cm_count | input | 2 | Number of oldest outstanding statuses committed |
| consume_idx | output | 8 | Consume index |
| ring_full | output | 1 | Descriptor ring is full |
| int_done_set | output | 1 | One-cycle done interrupt flag |
| int_err_set | output | 1 | One-cycle error interrupt flag |

## Verification
The engine is driven with runs of non-last fragments, which show that their statuses go out at once. Last fragments are given a delayed line-done pulse, which shows the hold and the merging of the line error. A stray done pulse before a last fragment shows that such a pulse is not remembered. Commit acknowledgements of counts 0, 1, 2 and 3 are applied against different numbers of outstanding statuses, which separates the clamped advance, the wrap of the consume index and interrupt flags that belong to later, not-yet-committed statuses. Filling the outstanding queue, holding the write back with `wr_ready` low and setting the produce index to several values exercise the stall, the stability of a pending write and the full rule around the wrap point.

// File: rtl/txstat_pkg.sv
// Shared definitions for the transmit status writeback engine.
// Assumes a 32-bit status word with an 11-bit byte count field.
package txstat_pkg;
    localparam int STAT_W  = 32;
    localparam int BYTES_W = 11;

    // Status word layout: error bit 31, last bit 30, byte count 10:0.
    typedef struct packed {
        logic               err;
        logic               last;
        logic [STAT_W-BYTES_W-3:0] zero;
        logic [BYTES_W-1:0] bytes;
    } stat_word_t;
endpackage

// File: rtl/txstat_stage.sv
// Single-entry staging register for one fragment status.
// A non-last fragment becomes eligible for writing at once; a last
// fragment becomes eligible only after the line-done pulse.
// Assumes the top writes the entry only while it is eligible.
module txstat_stage
    import txstat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frag_valid,
    output logic               frag_ready,
    input  logic               frag_last,
    input  logic               frag_irq,
    input  logic               frag_err,
    input  logic [BYTES_W-1:0] frag_bytes,
    input  logic               tx_done,
    input  logic               tx_done_err,
    input  logic               wr_fire,
    output logic               stage_ok,
    output stat_word_t         stage_word,
    output logic               stage_irq
);
    logic               held_v;
    logic               held_go;
    logic               held_last;
    logic               held_irq;
    logic               held_err;
    logic [BYTES_W-1:0] held_bytes;

    // Fragment accepted only when the single slot is empty.
    assign frag_ready = !held_v;

    // Slot contents: load on accept, merge line-done, clear on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v     <= 1'b0;
            held_go    <= 1'b0;
            held_last  <= 1'b0;
            held_irq   <= 1'b0;
            held_err   <= 1'b0;
            held_bytes <= '0;
        end else if (frag_valid && frag_ready) begin
            held_v     <= 1'b1;
            held_go    <= !frag_last;
            held_last  <= frag_last;
            held_irq   <= frag_irq;
            held_err   <= frag_err;
            held_bytes <= frag_bytes;
        end else begin
            if (wr_fire) begin
                held_v  <= 1'b0;
                held_go <= 1'b0;
            end else if (tx_done && held_v && !held_go) begin
                held_go  <= 1'b1;
                held_err <= held_err | tx_done_err;
            end
        end
    end

    // Status word assembly from the slot.
    always_comb begin
        stage_word       = '0;
        stage_word.err   = held_err;
        stage_word.last  = held_last;
        stage_word.bytes = held_bytes;
    end

    assign stage_ok  = held_v && held_go;
    assign stage_irq = held_irq;
endmodule

// File: rtl/txstat_pend_fifo.sv
// Queue of written but uncommitted statuses (interrupt and error flags).
// Pushes one entry per cycle, pops up to PEEK entries per cycle and
// exposes the oldest PEEK entries. Assumes pop_n never exceeds the count.
module txstat_pend_fifo #(
    parameter int DEPTH  = 4,
    parameter int PEEK   = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_irq,
    input  logic             push_err,
    input  logic [CNT_W-1:0] pop_n,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic [PEEK-1:0]  peek_irq,
    output logic [PEEK-1:0]  peek_err
);
    logic [DEPTH-1:0] mem_irq;
    logic [DEPTH-1:0] mem_err;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            count  <= count + CNT_W'(push) - pop_n;
        end
    end

    // Entry storage; written only on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_irq <= '0;
            mem_err <= '0;
        end else if (push) begin
            mem_irq[wr_ptr] <= push_irq;
            mem_err[wr_ptr] <= push_err;
        end
    end

    // Oldest entries, in age order.
    for (genvar g = 0; g < PEEK; g++) begin : g_peek
        logic [PTR_W-1:0] slot;
        assign slot        = rd_ptr + PTR_W'(g);
        assign peek_irq[g] = mem_irq[slot];
        assign peek_err[g] = mem_err[slot];
    end

    assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/txstat_commit.sv
// Commit handling: on an acknowledgement it retires up to BURST_MAX
// oldest outstanding statuses, advances the consume index with wrap and
// raises one-cycle interrupt flags. Assumes peek data is age ordered.
module txstat_commit #(
    parameter int IDX_W     = 8,
    parameter int BURST_MAX = 3,
    parameter int CNT_W     = 3,
    localparam int BW       = $clog2(BURST_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     cfg_desc_last,
    input  logic                 cm_valid,
    input  logic [BW-1:0]        cm_count,
    input  logic [CNT_W-1:0]     pend_count,
    input  logic [BURST_MAX-1:0] peek_irq,
    input  logic [BURST_MAX-1:0] peek_err,
    output logic [CNT_W-1:0]     pop_n,
    output logic [IDX_W-1:0]     consume_idx,
    output logic                 int_done_set,
    output logic                 int_err_set
);
    logic             irq_any;
    logic             err_any;
    logic [IDX_W-1:0] idx_next;

    // Number retired: requested count clamped to what is outstanding.
    always_comb begin
        pop_n = '0;
        if (cm_valid) begin
            if (CNT_W'(cm_count) > pend_count) pop_n = pend_count;
            else                               pop_n = CNT_W'(cm_count);
        end
    end

    // Flags of retired entries and the stepped consume index.
    always_comb begin
        irq_any  = 1'b0;
        err_any  = 1'b0;
        idx_next = consume_idx;
        for (int i = 0; i < BURST_MAX; i++) begin
            if (CNT_W'(i) < pop_n) begin
                irq_any  = irq_any | peek_irq[i];
                err_any  = err_any | peek_err[i];
                idx_next = (idx_next == cfg_desc_last) ? '0 : idx_next + IDX_W'(1);
            end
        end
    end

    // Registered consume index and interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            consume_idx  <= '0;
            int_done_set <= 1'b0;
            int_err_set  <= 1'b0;
        end else begin
            consume_idx  <= idx_next;
            int_done_set <= irq_any;
            int_err_set  <= err_any;
        end
    end
endmodule

// File: rtl/txstat_wb.sv
// Transmit status writeback engine top. Stages fragment statuses,
// writes them to base + 4 * status index, tracks uncommitted writes
// and advances the consume index on commit acknowledgements.
// Assumes cfg_desc_last and cfg_status_base change only while idle.
module txstat_wb
    import txstat_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int PEND_DEPTH = 4,
    parameter int BURST_MAX  = 3,
    localparam int CNT_W     = $clog2(PEND_DEPTH + 1),
    localparam int BW        = $clog2(BURST_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_status_base,
    input  logic [IDX_W-1:0]   cfg_desc_last,
    input  logic [IDX_W-1:0]   sw_produce_idx,
    input  logic               frag_valid,
    output logic               frag_ready,
    input  logic               frag_last,
    input  logic               frag_irq,
    input  logic               frag_err,
    input  logic [BYTES_W-1:0] frag_bytes,
    input  logic               tx_done,
    input  logic               tx_done_err,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [STAT_W-1:0]  wr_data,
    input  logic               cm_valid,
    input  logic [BW-1:0]      cm_count,
    output logic [IDX_W-1:0]   consume_idx,
    output logic               ring_full,
    output logic               int_done_set,
    output logic               int_err_set
);
    logic                 stage_ok;
    logic                 stage_irq;
    stat_word_t           stage_word;
    logic                 wr_fire;
    logic                 pend_full;
    logic [CNT_W-1:0]     pend_count;
    logic [CNT_W-1:0]     pop_n;
    logic [BURST_MAX-1:0] peek_irq;
    logic [BURST_MAX-1:0] peek_err;
    logic [IDX_W-1:0]     stat_idx;
    logic [IDX_W-1:0]     prod_next;

    txstat_stage u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .frag_valid  (frag_valid),
        .frag_ready  (frag_ready),
        .frag_last   (frag_last),
        .frag_irq    (frag_irq),
        .frag_err    (frag_err),
        .frag_bytes  (frag_bytes),
        .tx_done     (tx_done),
        .tx_done_err (tx_done_err),
        .wr_fire     (wr_fire),
        .stage_ok    (stage_ok),
        .stage_word  (stage_word),
        .stage_irq   (stage_irq)
    );

    // Write request: eligible status and room in the outstanding queue.
    assign wr_valid = stage_ok && !pend_full;
    assign wr_fire  = wr_valid && wr_ready;
    assign wr_data  = stage_word;
    assign wr_addr  = cfg_status_base + (ADDR_W'(stat_idx) << 2);

    // Status index: advances per accepted write, wraps at cfg_desc_last.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_idx <= '0;
        else if (wr_fire) stat_idx <= (stat_idx == cfg_desc_last) ? '0 : stat_idx + IDX_W'(1);
    end

    txstat_pend_fifo #(
        .DEPTH (PEND_DEPTH),
        .PEEK  (BURST_MAX)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_fire),
        .push_irq (stage_irq),
        .push_err (stage_word.err),
        .pop_n    (pop_n),
        .count    (pend_count),
        .full     (pend_full),
        .peek_irq (peek_irq),
        .peek_err (peek_err)
    );

    txstat_commit #(
        .IDX_W     (IDX_W),
        .BURST_MAX (BURST_MAX),
        .CNT_W     (CNT_W)
    ) u_commit (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_desc_last (cfg_desc_last),
        .cm_valid      (cm_valid),
        .cm_count      (cm_count),
        .pend_count    (pend_count),
        .peek_irq      (peek_irq),
        .peek_err      (peek_err),
        .pop_n         (pop_n),
        .consume_idx   (consume_idx),
        .int_done_set  (int_done_set),
        .int_err_set   (int_err_set)
    );

    // Ring full: produce index plus one (wrapped) meets the consume index.
    assign prod_next = (sw_produce_idx == cfg_desc_last) ? '0 : sw_produce_idx + IDX_W'(1);
    assign ring_full = (prod_next == consume_idx);
endmodule

// File: rtl/txstat_wb_chk.sv
// Protocol and ordering checks for txstat_wb, attached with bind.
// Assumes configuration inputs are constant while out of reset.
module txstat_wb_chk #(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  cfg_desc_last,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              pend_full,
    input logic              cm_valid,
    input logic [IDX_W-1:0]  consume_idx,
    input logic              int_done_set,
    input logic              int_err_set
);
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R11
    AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pend_full |-> !wr_valid); // R9
    AST_CONSUME_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_valid |=> $stable(consume_idx)); // R7
    AST_CONSUME_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        consume_idx <= cfg_desc_last); // R7
    AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int_done_set |-> $past(cm_valid)); // R8
    AST_ERR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int_err_set |-> $past(cm_valid)); // R8
endmodule

bind txstat_wb txstat_wb_chk #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_desc_last (cfg_desc_last),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .pend_full     (pend_full),
    .cm_valid      (cm_valid),
    .consume_idx   (consume_idx),
    .int_done_set  (int_done_set),
    .int_err_set   (int_err_set)
);

// File: tb/txstat_wb_tb.sv
// Scoreboard bench: the driver queues expected status writes, a monitor
// compares them as they leave the design; commits are checked directly.
module txstat_wb_tb;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [7:0]  LAST = 8'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sw_produce_idx = '0;
    logic        frag_valid = 1'b0, frag_last = 1'b0, frag_irq = 1'b0, frag_err = 1'b0;
    logic [10:0] frag_bytes = '0;
    logic        tx_done = 1'b0, tx_done_err = 1'b0;
    logic        wr_ready = 1'b1;
    logic        cm_valid = 1'b0;
    logic [1:0]  cm_count = '0;
    logic        frag_ready, wr_valid, ring_full, int_done_set, int_err_set;
    logic [31:0] wr_addr, wr_data;
    logic [7:0]  consume_idx;

    int checks = 0;
    int fails  = 0;
    logic [63:0] exp_q[$];   // {addr, data} expected writes
    logic [1:0]  flag_q[$];  // {irq, err} per written status, in order
    int wr_seen   = 0;
    int committed = 0;
    int m_sidx    = 0;       // model status index
    int m_cons    = 0;       // model consume index
    bit finished  = 0;

    always #2 clk = ~clk;    // 250 MHz

    txstat_wb u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_status_base(BASE), .cfg_desc_last(LAST),
        .sw_produce_idx(sw_produce_idx), .frag_valid(frag_valid), .frag_ready(frag_ready),
        .frag_last(frag_last), .frag_irq(frag_irq), .frag_err(frag_err),
        .frag_bytes(frag_bytes), .tx_done(tx_done), .tx_done_err(tx_done_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .cm_valid(cm_valid), .cm_count(cm_count), .consume_idx(consume_idx),
        .ring_full(ring_full), .int_done_set(int_done_set), .int_err_set(int_err_set)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Driver: offers one fragment, queues its expected status write.
    task automatic send(input logic [10:0] bytes, input bit last, input bit irq,
                        input bit err, input bit done_err);
        logic [31:0] word;
        while (!frag_ready) step();
        word = {err | (last & done_err), last, 19'd0, bytes};
        exp_q.push_back({BASE + 32'(m_sidx * 4), word});
        flag_q.push_back({irq, err | (last & done_err)});
        m_sidx = (m_sidx == int'(LAST)) ? 0 : m_sidx + 1;
        frag_valid = 1'b1; frag_bytes = bytes; frag_last = last;
        frag_irq = irq; frag_err = err;
        step();
        frag_valid = 1'b0;
    endtask

    task automatic pulse_done(input bit e);
        tx_done = 1'b1; tx_done_err = e;
        step();
        tx_done = 1'b0; tx_done_err = 1'b0;
    endtask

    // Commit: model retires min(n, outstanding) and predicts flags.
    task automatic commit(input int n, input string req);
        int k;
        bit ei = 0, ee = 0;
        k = wr_seen - committed;
        if (n < k) k = n;
        for (int i = 0; i < k; i++) begin
            logic [1:0] f;
            f = flag_q.pop_front();
            ei |= f[1]; ee |= f[0];
            m_cons = (m_cons == int'(LAST)) ? 0 : m_cons + 1;
        end
        committed += k;
        cm_valid = 1'b1; cm_count = 2'(n);
        step();
        cm_valid = 1'b0; cm_count = '0;
        check(consume_idx == 8'(m_cons), req, "consume_idx", 64'(consume_idx), 64'(m_cons));
        check(int_done_set == ei, "R8", "int_done_set", 64'(int_done_set), 64'(ei));
        check(int_err_set == ee, "R8", "int_err_set", 64'(int_err_set), 64'(ee));
    endtask

    // Monitor: compares each write at the edge where it is accepted.
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            logic [63:0] e;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected write", {wr_addr, wr_data}, 64'd0);
            end else begin
                e = exp_q.pop_front();
                check(wr_addr == e[63:32], "R3", "wr_addr", 64'(wr_addr), 64'(e[63:32]));
                check(wr_data == e[31:0], "R2", "wr_data", 64'(wr_data), 64'(e[31:0]));
            end
            wr_seen++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check(consume_idx == 0, "R1", "consume_idx", 64'(consume_idx), 0);
        check(!wr_valid, "R1", "wr_valid", 64'(wr_valid), 0);
        check(frag_ready, "R1", "frag_ready", 64'(frag_ready), 1);
        check(!int_done_set && !int_err_set, "R1", "int flags", 64'({int_done_set, int_err_set}), 0);

        // R4 non-last fragment written at once
        send(11'd100, 0, 0, 0, 0);
        check(wr_valid, "R4", "wr_valid after accept", 64'(wr_valid), 1);
        step();

        // R5 stray done ignored, last fragment waits for its own done
        pulse_done(1'b1);
        send(11'h7FF, 1, 1, 0, 1);
        for (int i = 0; i < 4; i++) begin
            check(!wr_valid, "R5", "wr_valid while waiting done", 64'(wr_valid), 0);
            check(!frag_ready, "R6", "frag_ready while staged", 64'(frag_ready), 0);
            step();
        end
        pulse_done(1'b1);
        check(wr_valid, "R5", "wr_valid after done", 64'(wr_valid), 1);
        repeat (2) step();

        // R7 no commit, no advance; count 0 has no effect
        check(consume_idx == 0, "R7", "consume before commit", 64'(consume_idx), 0);
        commit(0, "R7");
        commit(1, "R7");
        commit(3, "R7");  // clamped to one outstanding; irq and err

        // R9 outstanding queue full stalls writes
        for (int i = 0; i < 4; i++) send(11'(10 + i), 0, i == 3, i == 1, 0);
        repeat (2) step();
        send(11'd55, 0, 0, 0, 0);
        repeat (2) begin
            check(!wr_valid, "R9", "wr_valid when queue full", 64'(wr_valid), 0);
            step();
        end
        commit(2, "R7");
        repeat (2) step();
        commit(3, "R7");   // crosses wrap of consume index
        commit(2, "R7");

        // R10 ring full around the consume index
        sw_produce_idx = (m_cons == 0) ? LAST : 8'(m_cons - 1);
        #1 check(ring_full, "R10", "ring_full", 64'(ring_full), 1);
        sw_produce_idx = 8'(m_cons);
        #1 check(!ring_full, "R10", "ring_full not", 64'(ring_full), 0);
        sw_produce_idx = LAST;
        #1 check(ring_full == (m_cons == 0), "R10", "ring_full at wrap", 64'(ring_full), 64'(m_cons == 0));

        // R11 write held under backpressure
        wr_ready = 1'b0;
        step();
        send(11'd321, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) begin
            check(wr_valid && {wr_addr, wr_data} == exp_q[0], "R11", "held write",
                  {wr_addr, wr_data}, exp_q[0]);
            step();
        end
        wr_ready = 1'b1;
        repeat (2) step();
        check(exp_q.size() == 0, "R3", "writes left", 64'(exp_q.size()), 0);
        commit(1, "R7");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule